// File: doc/BRIEF.md
# Serial EEPROM Fetch Address Sequencer

This block produces the I2C read transactions that stream a configuration image out of serial EEPROM into a record loader, one byte at a time. It talks to a byte-level I2C master through a single-command handshake: it presents one command (start, repeated start, byte write, byte read with an acknowledge choice, or stop), waits until the master has taken it, then waits for the master's completion response before it presents the next one. Bit-level signalling on the wires belongs to the master.

Two layouts are supported, chosen when a fetch is started. In standard mode the image spans up to eight small devices at consecutive bus addresses above a base address. The sequencer selects each device with a one-byte offset of zero, reads the whole device and moves on to the next with a repeated start. In extended mode a single large device is selected with a two-byte offset of zero and read end to end. Every byte read is passed to the loader. When the loader flags the terminating frame, the sequencer closes the transfer cleanly and reports completion. If it runs off the end of the image before that, or if a written byte is not acknowledged, it stops the bus and raises an error level that serves as a hard-reset request.

Top module: `eeprom_fetch_seq`

## Requirements
- R1: In reset and after it, `busy_o`, `done_o`, `err_o`, `cmd_valid_o` and `byte_valid_o` are all low until `start_i` is seen.
- R2: A command is held on `cmd_op_o`/`cmd_data_o`/`cmd_ack_o` with `cmd_valid_o` high and unchanged until `cmd_ready_i`; the next command appears only after `rsp_valid_i`. Opcodes: 0 start, 1 repeated start, 2 write byte, 3 read byte, 4 stop.
- R3: Standard mode selects device d (from 0) with: start (repeated start for d>0), write `{BASE+d,0}`, write 0x00, repeated start, write `{BASE+d,1}`, then reads.
- R4: Extended mode issues start, write `{BASE,0}`, write 0x00, write 0x00, repeated start, write `{BASE,1}`, then reads, and never addresses any other device.
- R5: A read carries `cmd_ack_o`=1 when another read follows it and 0 when the next command is a repeated start or stop.
- R6: Each read response is forwarded on `byte_data_o` with `byte_valid_o` high for exactly one cycle, the cycle after `rsp_valid_i`, in fetch order.
- R7: In standard mode, after the last byte of device d (not the last device) the next commands select device d+1 beginning with a repeated start.
- R8: `last_frame_i` high while `byte_valid_o` is high ends the fetch: if that byte was read with a NACK a stop follows; otherwise one extra read with NACK, not forwarded, precedes the stop. `done_o` rises when the stop completes.
- R9: `last_frame_i` has no effect in any cycle where `byte_valid_o` is low.
- R10: Reaching the last byte of the last standard device, or of the extended space, with no terminator on that byte issues a stop and then raises `err_o`.
- R11: A write (device address or offset) answered with `rsp_nack_i` leads to a stop and then `err_o`.
- R12: `done_o`/`err_o` stay high until the next `start_i`; `start_i` while `busy_o` is high is ignored.
- R13: `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a fetch (when not busy) |
| mode_ext_i | input | 1 | 0 standard, 1 extended; sampled with start |
| cmd_valid_o | output | 1 | Command presented to the I2C master |
| cmd_ready_i | input | 1 | Master accepts the command |
| cmd_op_o | output | 3 | Command opcode (see R2) |
| cmd_data_o | output | 8 | Byte to write |
| cmd_ack_o | output | 1 | For reads: 1 ACK, 0 NACK |
| rsp_valid_i | input | 1 | Master finished the accepted command |
| rsp_data_i | input | 8 | Byte returned by a read |
| rsp_nack_i | input | 1 | Written byte was not acknowledged |
| byte_valid_o | output | 1 | Fetched byte valid to loader |
| byte_data_o | output | 8 | Fetched byte |
| last_frame_i | input | 1 | Loader saw the terminating frame |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | Fetch ended by terminator |
| err_o | output | 1 | Fetch failed; hard-reset request |

## Verification
A wrong position counter shows up at the ports within one device's worth of reads: the wrong device address or offset is written, so the slave model returns bytes that differ from the expected image, and the drain or stop comes one read early or late, which changes the command count. A wrong phase shows at the next command, as an unexpected opcode or an ACK flag that disagrees with what follows it. A wrong outcome flag shows at the end of the run as the wrong one of completion and error.

// File: rtl/eeprom_fetch_seq_pkg.sv
package eeprom_fetch_seq_pkg;

  // Opcodes seen by the I2C byte master
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } i2c_op_e;

  // Which command of the transfer is current
  typedef enum logic [3:0] {
    PH_SEL,    // start or repeated start before write address
    PH_DEVW,   // device address, write direction
    PH_OFFH,   // offset high byte (extended only)
    PH_OFFL,   // offset low byte
    PH_TURN,   // repeated start before read address
    PH_DEVR,   // device address, read direction
    PH_READ,   // data byte read
    PH_DRAIN,  // closing read after terminator, discarded
    PH_STOP
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_SHOW,
    ST_DONE,
    ST_FAIL
  } ctl_e;

endpackage

// File: rtl/fetch_cursor.sv
module fetch_cursor #(
  parameter int unsigned STD_DEVS  = 8,
  parameter int unsigned STD_BYTES = 256,
  parameter int unsigned EXT_AW    = 16,
  localparam int unsigned DEV_W    = (STD_DEVS > 1) ? $clog2(STD_DEVS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             ext_i,
  input  logic             step_byte_i,
  input  logic             step_dev_i,
  output logic [DEV_W-1:0] dev_o,
  output logic             first_dev_o,
  output logic             at_end_o,
  output logic             last_dev_o
);

  localparam int unsigned STD_OW = (STD_BYTES > 1) ? $clog2(STD_BYTES) : 1;
  localparam int unsigned CW     = (EXT_AW > STD_OW) ? EXT_AW : STD_OW;
  localparam logic [CW-1:0]    STD_LAST = CW'(STD_BYTES - 1);
  localparam logic [CW-1:0]    EXT_LAST = {{(CW-EXT_AW+1){1'b0}}, {EXT_AW{1'b1}}} [CW-1:0];
  localparam logic [DEV_W-1:0] DEV_LAST = DEV_W'(STD_DEVS - 1);

  logic [CW-1:0]    off_q;
  logic [DEV_W-1:0] dev_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      off_q <= '0;
      dev_q <= '0;
    end else if (step_dev_i) begin
      off_q <= '0;
      dev_q <= dev_q + 1'b1;
    end else if (step_byte_i) begin
      off_q <= off_q + 1'b1;
    end
  end

  assign dev_o       = dev_q;
  assign first_dev_o = (dev_q == '0);
  assign at_end_o    = ext_i ? (off_q == EXT_LAST) : (off_q == STD_LAST);
  assign last_dev_o  = ext_i | (dev_q == DEV_LAST);

endmodule

// File: rtl/fetch_cmd_encode.sv
module fetch_cmd_encode
  import eeprom_fetch_seq_pkg::*;
#(
  parameter int unsigned DEV_W    = 3,
  parameter logic [6:0]  DEV_BASE = 7'h50
) (
  input  phase_e           phase_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic             ext_i,
  input  logic             first_i,
  input  logic             at_end_i,
  output i2c_op_e          op_o,
  output logic [7:0]       data_o,
  output logic             ack_o
);

  logic [6:0] bus_addr;

  // Standard devices sit consecutively above the base address
  assign bus_addr = ext_i ? DEV_BASE : (DEV_BASE + 7'(dev_i));

  always_comb begin
    op_o   = OP_STOP;
    data_o = 8'h00;
    ack_o  = 1'b0;
    unique case (phase_i)
      PH_SEL:   op_o = first_i ? OP_START : OP_RSTART;
      PH_DEVW: begin
        op_o   = OP_WRITE;
        data_o = {bus_addr, 1'b0};
      end
      PH_OFFH,
      PH_OFFL:  op_o = OP_WRITE;
      PH_TURN:  op_o = OP_RSTART;
      PH_DEVR: begin
        op_o   = OP_WRITE;
        data_o = {bus_addr, 1'b1};
      end
      PH_READ: begin
        op_o  = OP_READ;
        ack_o = ~at_end_i;
      end
      PH_DRAIN: op_o = OP_READ;
      default:  op_o = OP_STOP;
    endcase
  end

endmodule

// File: rtl/eeprom_fetch_seq.sv
module eeprom_fetch_seq
  import eeprom_fetch_seq_pkg::*;
#(
  parameter int unsigned STD_DEVS  = 8,
  parameter int unsigned STD_BYTES = 256,
  parameter int unsigned EXT_AW    = 16,
  parameter logic [6:0]  DEV_BASE  = 7'h50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       mode_ext_i,
  output logic       cmd_valid_o,
  input  logic       cmd_ready_i,
  output logic [2:0] cmd_op_o,
  output logic [7:0] cmd_data_o,
  output logic       cmd_ack_o,
  input  logic       rsp_valid_i,
  input  logic [7:0] rsp_data_i,
  input  logic       rsp_nack_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_data_o,
  input  logic       last_frame_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);

  localparam int unsigned DEV_W = (STD_DEVS > 1) ? $clog2(STD_DEVS) : 1;

  ctl_e       st_q, st_n;
  phase_e     ph_q, ph_n;
  logic       ext_q, ext_n;
  logic       fail_q, fail_n;
  logic [7:0] byte_q, byte_n;
  logic       bv_q, bv_n;

  logic             cur_clr, cur_byte, cur_dev;
  logic [DEV_W-1:0] dev_w;
  logic             first_w, at_end_w, last_dev_w;
  i2c_op_e          op_w;
  logic             write_ph;

  fetch_cursor #(
    .STD_DEVS (STD_DEVS),
    .STD_BYTES(STD_BYTES),
    .EXT_AW   (EXT_AW)
  ) cursor_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (cur_clr),
    .ext_i      (ext_q),
    .step_byte_i(cur_byte),
    .step_dev_i (cur_dev),
    .dev_o      (dev_w),
    .first_dev_o(first_w),
    .at_end_o   (at_end_w),
    .last_dev_o (last_dev_w)
  );

  fetch_cmd_encode #(
    .DEV_W   (DEV_W),
    .DEV_BASE(DEV_BASE)
  ) encode_i (
    .phase_i (ph_q),
    .dev_i   (dev_w),
    .ext_i   (ext_q),
    .first_i (first_w),
    .at_end_i(at_end_w),
    .op_o    (op_w),
    .data_o  (cmd_data_o),
    .ack_o   (cmd_ack_o)
  );

  assign write_ph = (ph_q == PH_DEVW) || (ph_q == PH_OFFH) ||
                    (ph_q == PH_OFFL) || (ph_q == PH_DEVR);

  always_comb begin
    st_n     = st_q;
    ph_n     = ph_q;
    ext_n    = ext_q;
    fail_n   = fail_q;
    byte_n   = byte_q;
    bv_n     = 1'b0;
    cur_clr  = 1'b0;
    cur_byte = 1'b0;
    cur_dev  = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start_i) begin
          st_n    = ST_ISSUE;
          ph_n    = PH_SEL;
          ext_n   = mode_ext_i;
          fail_n  = 1'b0;
          cur_clr = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (cmd_ready_i) st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid_i) begin
          st_n = ST_ISSUE;
          if (write_ph && rsp_nack_i) begin
            fail_n = 1'b1;
            ph_n   = PH_STOP;
          end else begin
            unique case (ph_q)
              PH_SEL:   ph_n = PH_DEVW;
              PH_DEVW:  ph_n = ext_q ? PH_OFFH : PH_OFFL;
              PH_OFFH:  ph_n = PH_OFFL;
              PH_OFFL:  ph_n = PH_TURN;
              PH_TURN:  ph_n = PH_DEVR;
              PH_DEVR:  ph_n = PH_READ;
              PH_READ: begin
                byte_n = rsp_data_i;
                bv_n   = 1'b1;
                st_n   = ST_SHOW;
              end
              PH_DRAIN: ph_n = PH_STOP;
              default:  st_n = fail_q ? ST_FAIL : ST_DONE;
            endcase
          end
        end
      end
      ST_SHOW: begin
        st_n = ST_ISSUE;
        if (last_frame_i) begin
          // a byte already read with NACK can go straight to stop
          ph_n = at_end_w ? PH_STOP : PH_DRAIN;
        end else if (at_end_w) begin
          if (last_dev_w) begin
            fail_n = 1'b1;
            ph_n   = PH_STOP;
          end else begin
            cur_dev = 1'b1;
            ph_n    = PH_SEL;
          end
        end else begin
          cur_byte = 1'b1;
          ph_n     = PH_READ;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_SEL;
      ext_q  <= 1'b0;
      fail_q <= 1'b0;
      byte_q <= 8'h00;
      bv_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      ext_q  <= ext_n;
      fail_q <= fail_n;
      byte_q <= byte_n;
      bv_q   <= bv_n;
    end
  end

  assign cmd_valid_o  = (st_q == ST_ISSUE);
  assign cmd_op_o     = op_w;
  assign byte_valid_o = bv_q;
  assign byte_data_o  = byte_q;
  assign busy_o       = (st_q == ST_ISSUE) || (st_q == ST_WAIT) || (st_q == ST_SHOW);
  assign done_o       = (st_q == ST_DONE);
  assign err_o        = (st_q == ST_FAIL);

endmodule

// File: rtl/eeprom_fetch_seq_chk.sv
module eeprom_fetch_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic [2:0] cmd_op_o,
  input logic [7:0] cmd_data_o,
  input logic       cmd_ack_o,
  input logic       rsp_valid_i,
  input logic       byte_valid_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!cmd_valid_o && !byte_valid_o)); // R1

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o) && $stable(cmd_ack_o))); // R2

  AST_BYTE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> $past(rsp_valid_i)); // R6

  AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |=> !byte_valid_o); // R6

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
    (err_o && !start_i) |=> err_o); // R12

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o); // R12

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)); // R12

  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o)); // R13

endmodule

bind eeprom_fetch_seq eeprom_fetch_seq_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_op_o    (cmd_op_o),
  .cmd_data_o  (cmd_data_o),
  .cmd_ack_o   (cmd_ack_o),
  .rsp_valid_i (rsp_valid_i),
  .byte_valid_o(byte_valid_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/eeprom_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module eeprom_fetch_seq_tb_top;

  localparam int NDEV = 8;
  localparam int BPD  = 4;     // bytes per standard device in this bench
  localparam int EAW  = 4;
  localparam int EXTN = 16;    // extended space size
  localparam logic [6:0] BASE = 7'h50;
  localparam int OPS = 0, OPR = 1, OPW = 2, OPRD = 3, OPSP = 4;

  typedef struct packed {
    logic ext;
    int   term;      // byte index flagged as terminator, -1 none
    int   nack;      // command index answered with NACK, -1 none
    logic exp_err;
    int   exp_cmds;
    int   exp_bytes;
  } scen_t;

  localparam int NSC = 12;
  localparam scen_t SCN [0:NSC-1] = '{
    '{1'b0,  1, -1, 1'b0,  9,  2},   // std, terminator mid device 0
    '{1'b0,  3, -1, 1'b0, 10,  4},   // std, terminator on last byte of device 0
    '{1'b0, 10, -1, 1'b0, 28, 11},   // std, into device 2
    '{1'b0, -1, -1, 1'b1, 73, 32},   // std, wraps
    '{1'b0, 31, -1, 1'b0, 73, 32},   // std, terminator on very last byte
    '{1'b1,  0, -1, 1'b0,  9,  1},   // ext, first byte
    '{1'b1, 15, -1, 1'b0, 23, 16},   // ext, last byte
    '{1'b1, -1, -1, 1'b1, 23, 16},   // ext, wraps
    '{1'b0, -1,  1, 1'b1,  3,  0},   // std, device address NACK
    '{1'b1, -1,  3, 1'b1,  5,  0},   // ext, low offset NACK
    '{1'b0, -1, 11, 1'b1, 13,  4},   // std, offset NACK on device 1
    '{1'b1,  7, -1, 1'b0, 16,  8}    // ext, middle
  };

  logic clk = 1'b0;
  logic rst;
  logic start_i = 1'b0, mode_ext_i = 1'b0;
  logic cmd_valid_o, cmd_ready_i, cmd_ack_o;
  logic [2:0] cmd_op_o;
  logic [7:0] cmd_data_o;
  logic rsp_valid_i, rsp_nack_i;
  logic [7:0] rsp_data_i;
  logic byte_valid_o, last_frame_i;
  logic [7:0] byte_data_o;
  logic busy_o, done_o, err_o;

  always #4 clk = ~clk;

  eeprom_fetch_seq #(
    .STD_DEVS(NDEV), .STD_BYTES(BPD), .EXT_AW(EAW), .DEV_BASE(BASE)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_ext_i(mode_ext_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o),
    .cmd_data_o(cmd_data_o), .cmd_ack_o(cmd_ack_o), .rsp_valid_i(rsp_valid_i),
    .rsp_data_i(rsp_data_i), .rsp_nack_i(rsp_nack_i), .byte_valid_o(byte_valid_o),
    .byte_data_o(byte_data_o), .last_frame_i(last_frame_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  int checks = 0, failures = 0;
  int cur_term = -1, cur_nack = -1;
  logic cur_ext = 1'b0;
  int nlog, nbytes, data_err, ack_err, hold_err, addr_err;
  logic [2:0] lop [0:127];
  logic [7:0] ldat [0:127];

  function automatic logic [7:0] img(input int d, input int o);
    return 8'((d * 37 + o * 11 + 90) & 255);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // I2C master plus slave model, loader model
  initial begin
    int cyc = 0, dly = 0, s_addr = 0, s_ptr = 0;
    logic exp_addr = 1'b0, hold_pend = 1'b0, prev_rd = 1'b0, prev_ack = 1'b0;
    logic [2:0] h_op = '0;
    logic [7:0] h_dat = '0, pend_data = '0;
    logic pend_nack = 1'b0;
    cmd_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_nack_i = 1'b0;
    rsp_data_i = 8'h00; last_frame_i = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (nlog == 0) begin prev_rd = 1'b0; exp_addr = 1'b0; end
      if (hold_pend && !(cmd_valid_o && cmd_op_o == h_op && cmd_data_o == h_dat))
        hold_err++;
      hold_pend = 1'b0;
      rsp_valid_i = 1'b0; rsp_nack_i = 1'b0;
      if (dly > 0) begin
        dly--;
        if (dly == 0) begin
          rsp_valid_i = 1'b1; rsp_data_i = pend_data; rsp_nack_i = pend_nack;
        end
      end
      cmd_ready_i = 1'b0;
      if (cmd_valid_o && dly == 0 && !rsp_valid_i) begin
        if (cyc % 3 != 1) begin
          cmd_ready_i = 1'b1;
          if (nlog < 128) begin lop[nlog] = cmd_op_o; ldat[nlog] = cmd_data_o; end
          if (prev_rd && (prev_ack != (int'(cmd_op_o) == OPRD))) ack_err++;
          prev_rd = (int'(cmd_op_o) == OPRD);
          prev_ack = cmd_ack_o;
          pend_nack = 1'b0;
          pend_data = 8'h00;
          case (int'(cmd_op_o))
            OPS, OPR: exp_addr = 1'b1;
            OPW: begin
              pend_nack = (nlog == cur_nack);
              if (exp_addr) begin
                exp_addr = 1'b0;
                s_addr = int'(cmd_data_o[7:1]);
                if (!cmd_data_o[0]) s_ptr = 0;
                if (cur_ext && cmd_data_o[7:1] != BASE) addr_err++;
              end else begin
                s_ptr = ((s_ptr << 8) | int'(cmd_data_o)) & 16'hFFFF;
              end
            end
            OPRD: begin
              pend_data = img(s_addr - int'(BASE), s_ptr);
              s_ptr++;
            end
            default: ;
          endcase
          nlog++;
          dly = 2;
        end else begin
          hold_pend = 1'b1; h_op = cmd_op_o; h_dat = cmd_data_o;
        end
      end
      if (byte_valid_o) begin
        int d, o;
        d = cur_ext ? 0 : nbytes / BPD;
        o = cur_ext ? nbytes : nbytes % BPD;
        if (byte_data_o != img(d, o)) data_err++;
        last_frame_i = (nbytes == cur_term);
        nbytes++;
      end else begin
        last_frame_i = cyc[0];   // noise while no byte is shown (R9)
      end
    end
  end

  task automatic exp_head(input logic ext, input int i, output int op, output int dat);
    dat = -1;
    if (!ext) begin
      case (i)
        0: op = OPS;
        1: begin op = OPW; dat = {BASE, 1'b0}; end
        2: begin op = OPW; dat = 0; end
        3: op = OPR;
        4: begin op = OPW; dat = {BASE, 1'b1}; end
        default: op = OPRD;
      endcase
    end else begin
      case (i)
        0: op = OPS;
        1: begin op = OPW; dat = {BASE, 1'b0}; end
        2, 3: begin op = OPW; dat = 0; end
        4: op = OPR;
        default: begin op = OPW; dat = {BASE, 1'b1}; end
      endcase
    end
  endtask

  task automatic run(input scen_t s, input logic poke, input string nm);
    int wd = 0;
    cur_ext = s.ext; cur_term = s.term; cur_nack = s.nack;
    nlog = 0; nbytes = 0; data_err = 0; ack_err = 0; hold_err = 0; addr_err = 0;
    @(negedge clk);
    mode_ext_i = s.ext; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !done_o && !err_o, {nm, " R12 start accepted, outcome cleared"}, busy_o, 1);
    while (!(done_o || err_o) && wd < 5000) begin
      @(negedge clk);
      wd++;
      if (poke && wd == 6) begin mode_ext_i = ~s.ext; start_i = 1'b1; end
      if (poke && wd == 7) start_i = 1'b0;
    end
    chk(wd < 5000, {nm, " watchdog"}, wd, 0);
    chk(err_o == s.exp_err, {nm, " R8 R10 R11 outcome err"}, err_o, s.exp_err);
    chk(nlog == s.exp_cmds, {nm, " R8 command count"}, nlog, s.exp_cmds);
    chk(nbytes == s.exp_bytes, {nm, " R6 R9 bytes forwarded"}, nbytes, s.exp_bytes);
    chk(data_err == 0, {nm, " R6 byte data"}, data_err, 0);
    chk(ack_err == 0, {nm, " R5 ack flags"}, ack_err, 0);
    chk(hold_err == 0, {nm, " R2 command hold"}, hold_err, 0);
    chk(addr_err == 0, {nm, " R4 single device"}, addr_err, 0);
    chk(nlog > 0 && nlog <= 128 && int'(lop[nlog-1]) == OPSP, {nm, " R8 ends with stop"},
        (nlog > 0 && nlog <= 128) ? int'(lop[nlog-1]) : -1, OPSP);
    if (s.nack < 0) begin
      for (int i = 0; i < 6; i++) begin
        int eo, ed;
        exp_head(s.ext, i, eo, ed);
        chk(int'(lop[i]) == eo && (ed < 0 || int'(ldat[i]) == ed),
            {nm, s.ext ? " R4 header" : " R3 header"}, int'(ldat[i]), ed);
      end
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !done_o && !err_o && !byte_valid_o,
        "R1 in reset", busy_o, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !done_o && !err_o && !byte_valid_o,
        "R1 after reset", cmd_valid_o, 0);

    for (int k = 0; k < NSC; k++) begin
      run(SCN[k], 1'b0, $sformatf("scen%0d", k));
      if (k == 2) begin
        // device 1 follows device 0: commands 9 and 10 (R7)
        chk(int'(lop[9]) == OPR, "R7 repeated start to next device", int'(lop[9]), OPR);
        chk(ldat[10] == {BASE + 7'd1, 1'b0}, "R7 next device address",
            int'(ldat[10]), int'({BASE + 7'd1, 1'b0}));
      end
      if (k == 3) begin
        repeat (5) @(negedge clk);
        chk(err_o && !busy_o, "R12 error held", err_o, 1);
      end
    end

    repeat (5) @(negedge clk);
    chk(done_o && !err_o, "R12 done held", done_o, 1);

    // start during a fetch must not restart or change mode (R12)
    run(SCN[0], 1'b1, "poke");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule